// File: doc/BRIEF.md
# Multi-Level Trie Address Lookup

This block resolves a fixed-width address by walking a tree of linked tables kept in a word-addressed RAM that has a synchronous read port. Every table holds 2^N entries. The root table sits at table pointer 0. At each step the walk takes the next N address bits, starting from the most significant end, and uses them as the index inside the current table. An entry can be empty, can point to a lower table, or can be a leaf that carries a result word. The walk ends on the first empty entry or on the first leaf it reaches. It also ends when the last level holds an entry that is not a leaf.

The walk makes at most one RAM read per level. The worst-case number of reads, and therefore the worst-case latency, is known before the lookup starts. A lookup starts with a one-cycle `start_i` pulse. It finishes with a one-cycle `done_o` pulse, and `hit_o` and `data_o` are valid in that same cycle. The tables are built and maintained outside this block.

Top module: `trie_lookup`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, `done_o`, `hit_o` and `ram_rd_en_o` are low and `data_o` is zero.
- R2: Level k, counting from 0, indexes its table with address bits [ADDR_W-1-k*N -: N]. The read address is {table pointer, index}, so a table's base address is its pointer shifted left by N. The first read of every lookup uses pointer 0.
- R3: An entry word is DATA_W+2 bits wide. Bit DATA_W+1 is the valid flag and bit DATA_W is the leaf flag. Bits [DATA_W-1:0] hold the payload, and the low PTR_W bits of the payload are the next table pointer.
- R4: An entry whose valid flag is clear ends the lookup with `hit_o` low and `data_o` zero.
- R5: A valid entry with the leaf flag set ends the lookup with `hit_o` high and `data_o` equal to its payload. This applies at any level.
- R6: A valid entry that is not a leaf, found at the last level (ADDR_W/N - 1), ends the lookup as a miss.
- R7: A lookup that reads k levels issues exactly k single-cycle reads. `done_o` goes high exactly 2k cycles after the clock edge that accepted `start_i`.
- R8: `done_o` is high for exactly one cycle per accepted lookup.
- R9: A `start_i` that arrives while a lookup is in progress is ignored. It produces no extra result and does not change the result of the lookup in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a lookup when the block is idle |
| addr_i | input | ADDR_W | Address to look up, sampled together with start_i |
| ram_rd_en_o | output | 1 | RAM read strobe |
| ram_rd_addr_o | output | PTR_W+N | RAM read word address |
| ram_rd_data_i | input | DATA_W+2 | RAM read data, valid one cycle after the strobe |
| done_o | output | 1 | One-cycle pulse that marks the end of a lookup |
| hit_o | output | 1 | The lookup matched; valid while done_o is high |
| data_o | output | DATA_W | Leaf payload on a hit, zero on a miss |

## Verification
The bench drives full-depth hits, leaves that appear early at the root, empty entries at the root and at a middle level, and a last-level entry that has no leaf flag. A design that took level bits from the wrong end would return the wrong payload. A design that accepted an interior pointer at the bottom level would report a false hit or read past the tree. The all-ones and all-zeros index paths test the offset arithmetic at the table edges: an off-by-one base address would return a neighbouring entry. A second start pulse in the middle of a walk must leave no extra result in the scoreboard and no changed payload. Each result is also checked for its read count and its cycle latency, so a design that read one level too many or too few is caught.

// File: rtl/trie_pkg.sv
package trie_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EVAL = 2'd2
  } walk_state_t;
endpackage

// File: rtl/trie_level_sel.sv
module trie_level_sel #(
  parameter int ADDR_W = 20,
  parameter int N      = 5,
  parameter int LEVELS = ADDR_W / N,
  parameter int LVL_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LVL_W-1:0]  level,
  output logic [N-1:0]      bits
);
  logic [N-1:0] slice [LEVELS];

  // Level 0 owns the most significant N bits.
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = addr[ADDR_W-1-g*N -: N];
  end

  always_comb begin
    bits = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) bits = slice[i];
    end
  end
endmodule

// File: rtl/trie_entry_dec.sv
module trie_entry_dec #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 5
) (
  input  logic [DATA_W+1:0] word,
  output logic              valid,
  output logic              leaf,
  output logic [DATA_W-1:0] payload,
  output logic [PTR_W-1:0]  ptr
);
  assign valid   = word[DATA_W+1];
  assign leaf    = word[DATA_W];
  assign payload = word[DATA_W-1:0];
  assign ptr     = word[PTR_W-1:0];
endmodule

// File: rtl/trie_lookup.sv
module trie_lookup #(
  parameter int ADDR_W = 20,
  parameter int N      = 5,
  parameter int PTR_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                ram_rd_en_o,
  output logic [PTR_W+N-1:0]  ram_rd_addr_o,
  input  logic [DATA_W+1:0]   ram_rd_data_i,
  output logic                done_o,
  output logic                hit_o,
  output logic [DATA_W-1:0]   data_o
);
  import trie_pkg::*;

  localparam int LEVELS = ADDR_W / N;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int RAM_AW = PTR_W + N;

  walk_state_t        state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LVL_W-1:0]   level_q;

  logic [ADDR_W-1:0]  sel_addr;
  logic [LVL_W-1:0]   sel_lvl;
  logic [N-1:0]       sel_bits;
  logic               e_valid, e_leaf;
  logic [DATA_W-1:0]  e_payload;
  logic [PTR_W-1:0]   e_ptr;
  logic               last_lvl;

  // A fresh lookup indexes with the incoming address; later steps use the held copy.
  assign sel_addr = (state_q == ST_IDLE) ? addr_i : addr_q;
  assign sel_lvl  = (state_q == ST_IDLE) ? '0 : level_q + LVL_W'(1);
  assign last_lvl = (level_q == LVL_W'(LEVELS - 1));

  trie_level_sel #(
    .ADDR_W(ADDR_W), .N(N), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_sel (
    .addr (sel_addr),
    .level(sel_lvl),
    .bits (sel_bits)
  );

  trie_entry_dec #(
    .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_dec (
    .word   (ram_rd_data_i),
    .valid  (e_valid),
    .leaf   (e_leaf),
    .payload(e_payload),
    .ptr    (e_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      addr_q        <= '0;
      level_q       <= '0;
      ram_rd_en_o   <= 1'b0;
      ram_rd_addr_o <= '0;
      done_o        <= 1'b0;
      hit_o         <= 1'b0;
      data_o        <= '0;
    end else begin
      ram_rd_en_o <= 1'b0;
      done_o      <= 1'b0;
      hit_o       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q        <= addr_i;
            level_q       <= '0;
            ram_rd_en_o   <= 1'b1;
            ram_rd_addr_o <= {PTR_W'(0), sel_bits};
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: state_q <= ST_EVAL;
        ST_EVAL: begin
          if (!e_valid) begin
            done_o  <= 1'b1;
            data_o  <= '0;
            state_q <= ST_IDLE;
          end else if (e_leaf) begin
            done_o  <= 1'b1;
            hit_o   <= 1'b1;
            data_o  <= e_payload;
            state_q <= ST_IDLE;
          end else if (last_lvl) begin
            done_o  <= 1'b1;
            data_o  <= '0;
            state_q <= ST_IDLE;
          end else begin
            ram_rd_en_o   <= 1'b1;
            ram_rd_addr_o <= {e_ptr, sel_bits};
            level_q       <= level_q + LVL_W'(1);
            state_q       <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: result strobe lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: each read strobe is a single cycle, and results only follow an evaluated entry
  p_read_single_r7: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en_o |=> !ram_rd_en_o);
  p_done_after_eval_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(state_q) == ST_EVAL);

  // R5: a hit is only reported together with the result strobe
  p_hit_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> done_o);

  // R4: a miss returns zero data
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && !hit_o) |-> (data_o == '0));

  // R2: the first read goes to the root table, indexed by the top address bits
  p_root_read_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i) |=>
      (ram_rd_en_o && ram_rd_addr_o[RAM_AW-1:N] == '0 &&
       ram_rd_addr_o[N-1:0] == $past(addr_i[ADDR_W-1 -: N])));

  // R9: the held address is not disturbed while a walk is running
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(addr_q));
endmodule

// File: tb/trie_lookup_tb_top.sv
module trie_lookup_tb_top;
  localparam int ADDR_W  = 20;
  localparam int N       = 5;
  localparam int PTR_W   = 5;
  localparam int DATA_W  = 16;
  localparam int LEVELS  = ADDR_W / N;
  localparam int RAM_AW  = PTR_W + N;
  localparam int WORD_W  = DATA_W + 2;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic              hit;
    logic [DATA_W-1:0] data;
    int                reads;
    int                start_cyc;
    string             tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic ram_rd_en_o;
  logic [RAM_AW-1:0] ram_rd_addr_o;
  logic [WORD_W-1:0] ram_rd_data_i;
  logic done_o, hit_o;
  logic [DATA_W-1:0] data_o;

  logic [WORD_W-1:0] mem [1 << RAM_AW];
  exp_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int reads_seen = 0;
  int results = 0;
  int pushed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_ff @(posedge clk) begin
    if (ram_rd_en_o) ram_rd_data_i <= mem[ram_rd_addr_o];
  end

  trie_lookup #(.ADDR_W(ADDR_W), .N(N), .PTR_W(PTR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .ram_rd_en_o(ram_rd_en_o), .ram_rd_addr_o(ram_rd_addr_o),
    .ram_rd_data_i(ram_rd_data_i), .done_o(done_o), .hit_o(hit_o), .data_o(data_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // R3: entry word layout {valid, leaf, payload}
  task automatic put(input int ptr, input int idx, input bit v, input bit lf, input int pay);
    mem[(ptr << N) | idx] = {v, lf, DATA_W'(pay)};
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int a, input int b, input int c, input int d);
    return {N'(a), N'(b), N'(c), N'(d)};
  endfunction

  // Reference walk written from R2..R6
  function automatic exp_t model(input logic [ADDR_W-1:0] a);
    exp_t e;
    int ptr = 0;
    e.hit = 0; e.data = '0; e.reads = 0; e.start_cyc = 0; e.tag = "";
    for (int k = 0; k < LEVELS; k++) begin
      logic [WORD_W-1:0] w;
      w = mem[(ptr << N) | int'(a[ADDR_W-1-k*N -: N])];
      e.reads++;
      if (!w[DATA_W+1]) return e;
      if (w[DATA_W]) begin
        e.hit = 1; e.data = w[DATA_W-1:0]; return e;
      end
      if (k == LEVELS - 1) return e;
      ptr = int'(w[PTR_W-1:0]);
    end
    return e;
  endfunction

  task automatic lookup(input logic [ADDR_W-1:0] a, input string tag);
    exp_t e;
    e = model(a);
    @(negedge clk);
    start_i = 1'b1; addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    e.start_cyc = cyc;
    e.tag = tag;
    sbq.push_back(e);
    pushed++;
    repeat (2 * LEVELS + 2) @(negedge clk);
  endtask

  // Monitor: counts reads and compares each result with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (ram_rd_en_o) reads_seen++;
        if (done_o) begin
          results++;
          if (sbq.size() == 0) begin
            check(0, "R9 unexpected result", 1, 0);
          end else begin
            exp_t e;
            e = sbq.pop_front();
            check(hit_o == e.hit, {e.tag, " R5/R4/R6 hit"}, hit_o, e.hit);
            check(data_o == e.data, {e.tag, " R5/R4 data"}, data_o, e.data);
            check(reads_seen == e.reads, {e.tag, " R7 reads"}, reads_seen, e.reads);
            check(cyc - e.start_cyc == 2 * e.reads, {e.tag, " R7 latency"},
                  cyc - e.start_cyc, 2 * e.reads);
          end
          reads_seen = 0;
          @(negedge clk);
          check(!done_o, "R8 done single cycle", done_o, 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << RAM_AW); i++) mem[i] = '0;
    // Full path 3/7/1/x
    put(0, 3, 1, 0, 1);
    put(1, 7, 1, 0, 2);
    put(2, 1, 1, 0, 3);
    put(3, 30, 1, 1, 16'hBEEF);
    put(3, 31, 1, 0, 4);          // interior pointer at last level
    put(0, 10, 1, 1, 16'h1234);   // early leaf at root
    // All-ones path
    put(0, 31, 1, 0, 5);
    put(5, 31, 1, 0, 6);
    put(6, 31, 1, 0, 7);
    put(7, 31, 1, 1, 16'hFFFF);
    put(7, 0, 1, 1, 16'h0001);
    put(6, 0, 1, 1, 16'h00A5);    // leaf at level 2

    repeat (3) @(negedge clk);
    check(!done_o && !hit_o && !ram_rd_en_o && data_o == '0, "R1 reset outputs",
          {done_o, hit_o, ram_rd_en_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done_o && !hit_o && !ram_rd_en_o && data_o == '0, "R1 after release",
          {done_o, hit_o, ram_rd_en_o}, 0);

    lookup(mk(3, 7, 1, 30), "R2 full depth hit");
    lookup(mk(3, 7, 1, 31), "R6 interior at last level");
    lookup(mk(10, 0, 0, 0), "R5 early root leaf");
    lookup(mk(0, 0, 0, 0), "R4 empty root");
    lookup(mk(3, 9, 0, 0), "R4 empty level1");
    lookup(mk(3, 7, 1, 29), "R4 empty level3");
    lookup(mk(31, 31, 31, 31), "R3 all ones path");
    lookup(mk(31, 31, 31, 0), "R2 low edge index");
    lookup(mk(31, 31, 0, 17), "R5 leaf at level2");

    // R9: second start mid-walk must be ignored
    begin
      exp_t e;
      e = model(mk(3, 7, 1, 30));
      @(negedge clk);
      start_i = 1'b1; addr_i = mk(3, 7, 1, 30);
      @(negedge clk);
      start_i = 1'b0;
      e.start_cyc = cyc; e.tag = "R9 busy start";
      sbq.push_back(e); pushed++;
      repeat (2) @(negedge clk);
      start_i = 1'b1; addr_i = mk(10, 0, 0, 0);
      @(negedge clk);
      start_i = 1'b0;
      repeat (2 * LEVELS + 4) @(negedge clk);
    end

    for (int i = 0; i < 24; i++) begin
      int s = i * 40503 + 7;
      lookup(mk((i % 2) ? 31 : 3, (s >> 3) % 32, (s >> 7) % 2 ? 31 : 1, s % 32), "R2 sweep");
    end

    repeat (4) @(negedge clk);
    check(results == pushed && sbq.size() == 0, "R9 result count", results, pushed);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule